// File: doc/BRIEF.md
# Serial Search PN Code Acquisition

This block finds the code phase of a direct-sequence spread-spectrum signal at baseband. It takes one signed soft sample for each chip strobe and runs a local maximal-length pseudo-noise generator. It correlates the input against the local code over a programmable dwell that is shorter than the code period. If the magnitude of the correlation is below a programmable threshold, the block slips the local code by one chip and tries the next phase. When the magnitude exceeds the threshold, it declares lock and reports the local code phase.

A controller writes the dwell length and the threshold and pulses `start`. While the search runs, `busy` is high. The block tests one phase per dwell. A full search covers all 1023 phases, so the worst case is 1023 dwells plus one slip strobe after each dwell. When every phase has failed, `search_fail` pulses for one cycle and the search carries on from the current phase. Lock stays in place until the next `start`.

Top module: `pn_serial_acq`

## Requirements
- R1: After reset, `busy`, `locked` and `search_fail` are 0 and `lock_phase` is 0. The generator is at phase 0, where it outputs the seed's bit 0.
- R2: A `start` pulse clears `locked` and sets `busy` from the next cycle. It clears the accumulator, the dwell count and the miss count. The generator keeps its current phase. A `start` received while a search is running restarts that search.
- R3: The local chip at phase k is c[k]. The sequence is c[0..9] = seed bits 0..9 with seed 1, and c[n+10] = c[n] xor c[n+3], which has period 1023. While busy, each chip strobe adds +chip_in when c = 0 and -chip_in when c = 1, then advances the generator one phase. A dwell spans `dwell_len` strobes; a value of 0 is treated as 1.
- R4: At the end of a dwell, the block declares a hit only when the absolute value of the accumulated sum is strictly greater than `threshold`. A sum equal to the threshold is a miss. A large negative sum counts as a hit.
- R5: On a hit, `locked` goes to 1 and `busy` goes to 0 in the next cycle. `lock_phase` then holds the phase the generator would use for the next chip. Both values hold until the next `start`.
- R6: After a miss, the next chip strobe is consumed without accumulating and without advancing the generator. This retards the local code by one chip relative to the input. The next dwell then begins.
- R7: On the 1023rd consecutive miss, `search_fail` is high for exactly one cycle. The miss count then restarts and `busy` stays 1.
- R8: While `chip_en` is 0 and `start` is 0, no accumulator, counter or generator state changes.
- R9: The phase count wraps from 1022 to 0, so `lock_phase` is always below 1023 and matches the generator's phase after any number of advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or restart a search |
| chip_en | input | 1 | Chip strobe; `chip_in` is valid |
| chip_in | input | 8 | Signed soft chip sample |
| dwell_len | input | 10 | Chips per dwell; 0 acts as 1 |
| threshold | input | 19 | Unsigned correlation magnitude threshold |
| busy | output | 1 | Search in progress |
| locked | output | 1 | Phase acquired |
| lock_phase | output | 10 | Generator phase for the next chip at lock |
| search_fail | output | 1 | One-cycle pulse after a full period of misses |

## Verification
The bench builds the block with its default parameters: a 10-bit generator with period 1023, 8-bit samples and a 10-bit dwell count. With these values, the 1023-miss failure pulse and the phase wrap are reachable in about two thousand strobes. The stimulus covers several cases:
- a received code offset by three chips, which forces three slips before lock;
- an inverted code, which gives a large negative sum;
- a correlation exactly equal to the threshold, against one just above it;
- a zero dwell length;
- a long run of zero input that exhausts the full period and wraps the phase.

// File: rtl/pn_serial_acq.sv
module pn_serial_acq #(
  parameter int LFSR_W = 10,
  parameter logic [LFSR_W-1:0] TAPS = 'h009,
  parameter logic [LFSR_W-1:0] SEED = 'h001,
  parameter int SAMP_W = 8,
  parameter int DWELL_W = 10,
  localparam int ACC_W = SAMP_W + DWELL_W + 1,
  localparam int PERIOD = (1 << LFSR_W) - 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     chip_en,
  input  logic signed [SAMP_W-1:0] chip_in,
  input  logic [DWELL_W-1:0]       dwell_len,
  input  logic [ACC_W-1:0]         threshold,
  output logic                     busy,
  output logic                     locked,
  output logic [LFSR_W-1:0]        lock_phase,
  output logic                     search_fail
);

  localparam logic [LFSR_W-1:0] LAST_PH = LFSR_W'(PERIOD - 1);

  logic [LFSR_W-1:0]       lfsr, phase, tested;
  logic [DWELL_W-1:0]      cnt;
  logic signed [ACC_W-1:0] acc;
  logic                    slip;

  logic signed [ACC_W-1:0] samp_x, prod, acc_nx;
  logic [ACC_W-1:0]        mag;
  logic [DWELL_W:0]        cnt_p1;
  logic [LFSR_W-1:0]       lfsr_nx, phase_nx;
  logic                    last, hit;

  assign samp_x   = chip_in;
  assign prod     = lfsr[0] ? -samp_x : samp_x;
  assign acc_nx   = acc + prod;
  assign mag      = acc_nx[ACC_W-1] ? -acc_nx : acc_nx;
  assign cnt_p1   = {1'b0, cnt} + 1'b1;
  assign last     = cnt_p1 >= {1'b0, dwell_len};
  assign hit      = mag > threshold;
  assign lfsr_nx  = {^(lfsr & TAPS), lfsr[LFSR_W-1:1]};
  assign phase_nx = (phase == LAST_PH) ? '0 : phase + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= SEED; phase <= '0; tested <= '0; cnt <= '0; acc <= '0;
      slip <= 1'b0; busy <= 1'b0; locked <= 1'b0; lock_phase <= '0;
      search_fail <= 1'b0;
    end else begin
      search_fail <= 1'b0;
      if (start) begin
        busy <= 1'b1; locked <= 1'b0; acc <= '0; cnt <= '0;
        tested <= '0; slip <= 1'b0;
      end else if (busy && chip_en) begin
        if (slip) begin
          slip <= 1'b0;
        end else begin
          lfsr  <= lfsr_nx;
          phase <= phase_nx;
          if (last) begin
            acc <= '0;
            cnt <= '0;
            if (hit) begin
              locked     <= 1'b1;
              busy       <= 1'b0;
              lock_phase <= phase_nx;
            end else begin
              slip <= 1'b1;
              if (tested == LAST_PH) begin
                search_fail <= 1'b1;
                tested      <= '0;
              end else begin
                tested <= tested + 1'b1;
              end
            end
          end else begin
            acc <= acc_nx;
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  AST_LOCK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && busy)); // R5
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && !locked); // R2
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !start |=> locked && $stable(lock_phase)); // R5
  AST_SLIP_HOLDS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && chip_en && slip && !start |=> $stable(lfsr) && $stable(acc) && !slip); // R6
  AST_IDLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en && !start |=> $stable(lfsr) && $stable(acc) && $stable(cnt) && $stable(phase)); // R8
  AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    search_fail |=> !search_fail && busy); // R7
  AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0); // R3
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST_PH && lock_phase <= LAST_PH); // R9

endmodule

// File: tb/pn_serial_acq_tb.sv
module pn_serial_acq_tb;
  localparam int P = 1023;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, chip_en = 1'b0;
  logic signed [7:0] chip_in = '0;
  logic [9:0] dwell_len = 10'd1;
  logic [18:0] threshold = '0;
  logic busy, locked, search_fail;
  logic [9:0] lock_phase;

  pn_serial_acq u_dut (.clk(clk), .rst_n(rst_n), .start(start), .chip_en(chip_en),
    .chip_in(chip_in), .dwell_len(dwell_len), .threshold(threshold), .busy(busy),
    .locked(locked), .lock_phase(lock_phase), .search_fail(search_fail));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0, rxp = 0;
  bit code [P];

  int m_ph, m_cnt, m_tested, m_lock;
  longint m_acc;
  bit m_busy, m_locked, m_slip, m_fail;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_tested = 0; m_acc = 0; m_lock = 0;
      m_busy = 0; m_locked = 0; m_slip = 0; m_fail = 0;
    end else begin
      m_fail = 0;
      if (start) begin
        m_busy = 1; m_locked = 0; m_acc = 0; m_cnt = 0; m_tested = 0; m_slip = 0;
      end else if (m_busy && chip_en) begin
        if (m_slip) m_slip = 0;
        else begin
          m_acc += code[m_ph] ? -longint'(chip_in) : longint'(chip_in);
          m_ph = (m_ph + 1) % P;
          if (m_cnt + 1 >= int'(dwell_len)) begin
            if ((m_acc < 0 ? -m_acc : m_acc) > longint'(threshold)) begin
              m_locked = 1; m_busy = 0; m_lock = m_ph;
            end else begin
              m_slip = 1;
              if (m_tested == P - 1) begin m_fail = 1; m_tested = 0; end
              else m_tested++;
            end
            m_acc = 0; m_cnt = 0;
          end else m_cnt++;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    check(busy === m_busy, rst_n ? "R5" : "R1", "busy", busy, m_busy);
    check(locked === m_locked, rst_n ? "R5" : "R1", "locked", locked, m_locked);
    check(lock_phase === 10'(m_lock), rst_n ? "R9" : "R1", "lock_phase", lock_phase, m_lock);
    check(search_fail === m_fail, rst_n ? "R7" : "R1", "search_fail", search_fail, m_fail);
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic chip(int v); chip_en = 1'b1; chip_in = 8'(v); tick(); endtask
  task automatic do_start(int dl, int th);
    chip_en = 1'b0; dwell_len = 10'(dl); threshold = 19'(th); start = 1'b1; tick();
    start = 1'b0;
  endtask
  function automatic int rx(int amp, int nz);
    int v = (code[rxp] ? -amp : amp) + nz;
    rxp = (rxp + 1) % P;
    return v;
  endfunction

  initial begin
    int n, pulses;
    for (int i = 0; i < 10; i++) code[i] = (i == 0);
    for (int i = 10; i < P; i++) code[i] = code[i-10] ^ code[i-7];
    repeat (3) tick();
    rst_n = 1'b1; tick();
    check(!busy && !locked && !search_fail && lock_phase == 0, "R1", "reset outputs",
          {busy, locked, search_fail}, 0);

    do_start(32, 400);
    check(busy && !locked, "R2", "start arms", {busy, locked}, 2);
    chip_en = 1'b0; chip_in = 8'sd100; repeat (10) tick();
    check(busy && !locked, "R8", "idle strobes ignored", {busy, locked}, 2);

    rxp = (m_ph + P - 3) % P; n = 0;
    while (!locked && n < 2000) begin chip(rx(20, (n % 3) - 1)); n++; end
    chip_en = 1'b0; tick();
    check(locked, "R6", "lock after slips", locked, 1);
    check(n == 3 * 33 + 32, "R6", "strobes to lock", n, 3 * 33 + 32);
    check(int'(lock_phase) == rxp, "R5", "lock phase aligned", lock_phase, rxp);

    for (int i = 0; i < 20; i++) chip(rx(20, 0));
    chip_en = 1'b0; tick();
    check(locked && !busy && int'(lock_phase) == m_lock, "R5", "lock held", lock_phase, m_lock);

    do_start(8, 100);
    rxp = m_ph; n = 0;
    while (!locked && n < 100) begin chip(-rx(20, 0)); n++; end
    chip_en = 1'b0; tick();
    check(locked && n == 8, "R3", "inverted code locks in one dwell", n, 8);

    do_start(1, 20);
    for (int i = 0; i < 4; i++) chip(rx(20, 0));
    chip_en = 1'b0; tick();
    check(!locked && busy, "R4", "equal to threshold is a miss", locked, 0);
    do_start(1, 19);
    chip(rx(20, 0)); chip_en = 1'b0; tick();
    check(locked, "R4", "above threshold hits", locked, 1);

    do_start(0, 19);
    chip(rx(-20, 0)); chip_en = 1'b0; tick();
    check(locked, "R3", "zero dwell acts as one", locked, 1);

    do_start(1, 100);
    pulses = 0;
    for (int i = 0; i < 2 * P; i++) begin chip(0); if (search_fail) pulses++; end
    chip_en = 1'b0; tick(); if (search_fail) pulses++;
    check(pulses == 1, "R7", "one fail pulse per period", pulses, 1);
    check(busy && !locked, "R7", "search continues", busy, 1);

    do_start(16, 200);
    rxp = m_ph; n = 0;
    while (!locked && n < 100) begin chip(rx(20, 0)); n++; end
    chip_en = 1'b0; tick();
    check(locked && int'(lock_phase) == rxp && lock_phase < 10'(P), "R9",
          "phase after wrap", lock_phase, rxp);

    repeat (3) tick();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule